// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control and status front end of a successive-approximation converter. Software programs it through two small registers: a control word (enable, start, auto-trigger enable, interrupt enable, completion flag, 3-bit converter clock divider code) and a channel word (4-bit input select plus a free-running select). The block times each conversion with a divided converter clock and drives the channel code to the analog multiplexer. When a conversion finishes it raises the completion flag, and an interrupt request when the interrupt enable is set. A cycle counter stands in for the analog converter's done signal.

Conversions start in three ways. A software start begins a single conversion. In triggered mode, a rising edge on the trigger input starts one. In free-running mode, a software start begins a chain of back-to-back conversions. A channel change or a disable written while a conversion runs is held back until that conversion ends. The first conversion after enabling includes an initialisation phase and is longer. The channel code is passed unchanged to the multiplexer: codes 0 to 10 select external inputs, 11 and 12 select amplifier outputs, 13 is reserved, 14 selects the bandgap reference and 15 selects ground.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every control word bit reads 0, the channel word reads 0, the channel select output is 0 and the interrupt request is low.
- R2: The control word layout is: bit 0 enable, bit 1 start/busy, bit 2 auto-trigger enable, bit 3 interrupt enable, bit 4 completion flag, bits 7:5 divider code. Writing 1 to bit 1 while the block is idle and the written enable is 1 starts a conversion. Bit 1 reads 1 while a conversion runs and clears itself on completion. Writing 0 to bit 1 has no effect. A start written with enable 0 is ignored.
- R3: A conversion lasts the conversion's converter-clock count times the divider, in system clocks. The divider is 2 for codes 0 and 1, and 2^code for codes 2 to 7.
- R4: The first conversion after the enable goes from 0 to 1 lasts 25 converter clocks. Every later conversion lasts 13.
- R5: The channel word holds the channel code in bits 3:0 and the free-running select in bit 4. A channel written while idle reaches the channel select output on the next cycle. A channel written during a conversion reads back at once but reaches the output only when that conversion completes.
- R6: Clearing the enable during a conversion lets that conversion run to its full length and set the flag. Afterwards the block is disabled, a start is ignored, and the next enable begins again with a 25-clock conversion.
- R7: The completion flag sets when a conversion ends. Writing 1 to bit 4 clears it and writing 0 leaves it unchanged. The interrupt request is high exactly while both the flag and the interrupt enable are 1.
- R8: With auto-trigger enabled, a rising edge on the trigger input starts a conversion only while the block is enabled and idle. An edge during a conversion, or with auto-trigger disabled, starts nothing.
- R9: With auto-trigger and free-running both selected, each completion starts the next conversion at once. Clearing auto-trigger lets the current conversion finish and then stops the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| chan_we | input | 1 | Channel word write strobe |
| chan_wdata | input | 5 | Channel word write data |
| trig_in | input | 1 | Conversion trigger, rising-edge sensitive |
| ctl_rdata | output | 8 | Control word read value |
| chan_rdata | output | 5 | Channel word read value (last written) |
| mux_sel | output | 4 | Channel code applied to the analog multiplexer |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures how long each conversion stays busy for several divider codes, separately for the first and for later conversions. A divider, or a missing initialisation phase, would show up as a wrong count. It writes a channel and a disable in the middle of a conversion. A design that applied either at once would switch the multiplexer early or cut the conversion short with no flag. It fires triggers during a conversion and with auto-trigger off, where a design that did not filter them would start extra conversions. It also checks that writing 0 to the flag or to the start bit changes nothing, so a plain-write flag or a start bit that a write can clear would show.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int CH_W = 4;
    localparam int PS_W = 3;

    localparam int B_EN   = 0;
    localparam int B_BUSY = 1;
    localparam int B_AUTO = 2;
    localparam int B_IE   = 3;
    localparam int B_FLAG = 4;
    localparam int B_PS   = 5;
    localparam int B_FREE = CH_W;

    typedef struct packed {
        logic            en;
        logic            busy;
        logic            auto_tr;
        logic            ie;
        logic            flag;
        logic [PS_W-1:0] presc;
        logic [CH_W-1:0] chan_wr;
        logic            free;
        logic [CH_W-1:0] chan_act;
        logic            en_act;
        logic            first;
        logic            trig;
    } seq_state_t;
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic [PS_W-1:0] psel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(psel)) mask[i] = 1'b1;
        end
        if (psel == '0) mask[0] = 1'b1;
        tick  = ((cnt_q & mask) == mask);
        cnt_d = clear ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int NORM_CLKS = 13,
    parameter int INIT_CLKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    input  logic long_mode,
    output logic done
);
    localparam int CNT_W = $clog2(INIT_CLKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last  = long_mode ? CNT_W'(INIT_CLKS - 1) : CNT_W'(NORM_CLKS - 1);
        done  = !clear && tick && (cnt_q == last);
        cnt_d = cnt_q;
        if (clear || done) cnt_d = '0;
        else if (tick)     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NORM_CLKS = 13,
    parameter int INIT_CLKS = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [7:0]      ctl_wdata,
    input  logic            chan_we,
    input  logic [CH_W:0]   chan_wdata,
    input  logic            trig_in,
    output logic [7:0]      ctl_rdata,
    output logic [CH_W:0]   chan_rdata,
    output logic [CH_W-1:0] mux_sel,
    output logic            irq
);
    seq_state_t st_d, st_q;
    logic       conv_done;
    logic       tick;
    logic       holding;
    logic       trig_rise;
    logic       start_req;

    adc_seq_clkdiv #(.PS_W(PS_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!st_q.busy || conv_done),
        .psel  (st_q.presc),
        .tick  (tick)
    );

    adc_seq_timer #(.NORM_CLKS(NORM_CLKS), .INIT_CLKS(INIT_CLKS)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!st_q.busy),
        .tick      (tick),
        .long_mode (st_q.first),
        .done      (conv_done)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = trig_in;
        trig_rise = trig_in && !st_q.trig;
        holding   = st_q.busy && !conv_done;

        if (ctl_we) begin
            st_d.en      = ctl_wdata[B_EN];
            st_d.auto_tr = ctl_wdata[B_AUTO];
            st_d.ie      = ctl_wdata[B_IE];
            st_d.presc   = ctl_wdata[B_PS +: PS_W];
            if (ctl_wdata[B_FLAG]) st_d.flag = 1'b0;
        end
        if (chan_we) begin
            st_d.chan_wr = chan_wdata[CH_W-1:0];
            st_d.free    = chan_wdata[B_FREE];
        end
        if (conv_done) st_d.flag = 1'b1;

        if (!holding) begin
            st_d.chan_act = st_d.chan_wr;
            st_d.en_act   = st_d.en;
        end

        start_req = (ctl_we && ctl_wdata[B_BUSY]) || (st_q.auto_tr && trig_rise);
        if (holding)        st_d.busy = 1'b1;
        else if (conv_done) st_d.busy = st_d.en && st_d.auto_tr && st_d.free;
        else                st_d.busy = st_d.en && start_req;

        if (conv_done)    st_d.first = 1'b0;
        if (!st_d.en_act) st_d.first = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl_rdata               = '0;
        ctl_rdata[B_EN]         = st_q.en;
        ctl_rdata[B_BUSY]       = st_q.busy;
        ctl_rdata[B_AUTO]       = st_q.auto_tr;
        ctl_rdata[B_IE]         = st_q.ie;
        ctl_rdata[B_FLAG]       = st_q.flag;
        ctl_rdata[B_PS +: PS_W] = st_q.presc;
        chan_rdata              = {st_q.free, st_q.chan_wr};
        mux_sel                 = st_q.chan_act;
        irq                     = st_q.flag && st_q.ie;
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_rdata,
    input logic [3:0] mux_sel,
    input logic       conv_done
);
    // R2: a conversion only begins while enabled
    p_start_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[1]) |-> ctl_rdata[0]);

    // R3: completion only happens inside a running conversion
    p_done_in_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> ctl_rdata[1]);

    // R5: the multiplexer code is frozen while a conversion runs
    p_mux_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1] && !conv_done) |=> $stable(mux_sel));

    // R6: a running conversion is never abandoned
    p_conv_runs_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1] && !conv_done) |=> ctl_rdata[1]);

    // R7: the flag follows every completion
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> ctl_rdata[4]);

    // R7: the flag rises only because of a completion
    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[4]) |-> $past(conv_done));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rdata (ctl_rdata),
    .mux_sel   (mux_sel),
    .conv_done (conv_done)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       chan_we = 1'b0;
    logic [4:0] chan_wdata = '0;
    logic       trig_in = 1'b0;
    logic [7:0] ctl_rdata;
    logic [4:0] chan_rdata;
    logic [3:0] mux_sel;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    // control bits: 0 en, 1 start, 2 auto, 3 ie, 4 flag, 7:5 divider code
    localparam logic [7:0] EN = 8'h01, ST = 8'h02, AU = 8'h04, IE = 8'h08, FL = 8'h10;

    // divider code, first conversion length, later conversion length (system clocks)
    localparam int VEC[5][3] = '{'{0, 50, 26}, '{1, 50, 26}, '{2, 100, 52},
                                 '{3, 200, 104}, '{7, 3200, 1664}};

    always #5 clk = ~clk;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .chan_we(chan_we), .chan_wdata(chan_wdata), .trig_in(trig_in),
        .ctl_rdata(ctl_rdata), .chan_rdata(chan_rdata), .mux_sel(mux_sel), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wr_chan(input logic [4:0] v);
        @(negedge clk); chan_we = 1'b1; chan_wdata = v;
        @(negedge clk); chan_we = 1'b0; chan_wdata = '0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (ctl_rdata[1] && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 ctl", int'(ctl_rdata), 0);
        chk("R1 chan", int'(chan_rdata), 0);
        chk("R1 mux", int'(mux_sel), 0);
        chk("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start with enable 0 is ignored
        wr_ctl(ST);
        chk("R2 start ignored when disabled", int'(ctl_rdata[1]), 0);

        // R3 / R4: table of divider codes
        for (int i = 0; i < 5; i++) begin
            logic [7:0] ps;
            ps = 8'(VEC[i][0] << 5);
            wr_ctl(8'h00);
            wr_ctl(EN | ST | ps);
            busy_len(n);
            chk("R4 first conversion length", n, VEC[i][1]);
            wr_ctl(EN | ST | ps);
            busy_len(n);
            chk("R3 conversion length", n, VEC[i][2]);
        end

        // R7: flag set, write 0 keeps it, write 1 clears it, irq follows
        wr_ctl(8'h00);
        wr_ctl(EN | ST);
        busy_len(n);
        chk("R7 flag set", int'(ctl_rdata[4]), 1);
        chk("R7 irq low without ie", int'(irq), 0);
        wr_ctl(EN | IE);
        chk("R7 flag kept by write 0", int'(ctl_rdata[4]), 1);
        chk("R7 irq with ie", int'(irq), 1);
        wr_ctl(EN | IE | FL);
        chk("R7 flag cleared", int'(ctl_rdata[4]), 0);
        chk("R7 irq cleared", int'(irq), 0);

        // R5: channel write while idle and during a conversion
        wr_chan(5'd5);
        chk("R5 idle channel applied", int'(mux_sel), 5);
        wr_ctl(EN | ST);
        wr_chan(5'd15);
        chk("R5 mux held during conversion", int'(mux_sel), 5);
        chk("R5 readback new channel", int'(chan_rdata), 15);
        busy_len(n);
        chk("R5 channel applied at completion", int'(mux_sel), 15);

        // R2: writing 0 to start during a conversion has no effect
        wr_ctl(EN | ST);
        wr_ctl(EN);
        chk("R2 start 0 write ignored", int'(ctl_rdata[1]), 1);
        busy_len(n);
        chk("R2 busy clears after conversion", n, 24);

        // R6: disable mid-conversion
        wr_ctl(EN | ST | FL);
        idle_cycles(4);
        wr_ctl(8'h00);
        busy_len(n);
        chk("R6 conversion runs to the end", n, 20);
        chk("R6 flag after disabled conversion", int'(ctl_rdata[4]), 1);
        chk("R6 enable reads 0", int'(ctl_rdata[0]), 0);
        wr_ctl(ST);
        chk("R6 start ignored after disable", int'(ctl_rdata[1]), 0);
        wr_ctl(EN | ST);
        busy_len(n);
        chk("R6 re-enable first conversion long", n, 50);

        // R8: triggers
        pulse_trig();
        chk("R8 trigger ignored without auto", int'(ctl_rdata[1]), 0);
        wr_ctl(EN | AU);
        pulse_trig();
        chk("R8 trigger starts", int'(ctl_rdata[1]), 1);
        idle_cycles(3);
        pulse_trig();
        busy_len(n);
        chk("R8 trigger during conversion ignored (length)", n, 21);
        idle_cycles(5);
        chk("R8 no conversion from busy trigger", int'(ctl_rdata[1]), 0);

        // R9: free-running chain
        wr_chan(5'h12);
        wr_ctl(EN | AU | ST | FL);
        idle_cycles(81);
        chk("R9 free-running still busy", int'(ctl_rdata[1]), 1);
        chk("R9 flag set by chain", int'(ctl_rdata[4]), 1);
        wr_ctl(EN);
        busy_len(n);
        chk("R9 chain ends within one conversion", int'(n <= 26), 1);
        idle_cycles(40);
        chk("R9 stays idle after auto cleared", int'(ctl_rdata[1]), 0);
        chk("R9 channel used", int'(mux_sel), 2);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule